// File: doc/BRIEF.md
# D-PHY Receiver Start-Up Sequencer

This block brings a D-PHY receive front end into operation without software involvement. A one-cycle start request carries the link data rate in Mbit/s and the number of active lanes. The block captures both values and sets the lane control fields for receive-only operation. It then pulses the PHY test-clear line with two settle intervals and programs the PHY's internal configuration registers through its serial test port. When the last of those writes is finished, it pulses done.

The data rate selects a six-bit frequency-band code. The code comes from an ascending list of 39 upper rate bounds, and the first bound that is not below the rate wins. The register writes are produced by toggling a test clock, a test enable and an eight-bit test data bus. The PHY takes the register address on the falling test-clock edge while enable is high. It takes the data byte on the next rising edge while enable is low. Every step of this handshake is held for a parameterised number of system clocks, so that a slow PHY test port meets its setup and hold times. The settle intervals come from a cycle counter whose length is the product of the clock frequency in MHz and the wait in microseconds.

Top module: `dphy_rx_startup`

## Requirements
- R1: After synchronous reset, every output is zero: busy, done, the lane control fields, test clock, test clear, test enable and test data.
- R2: A start accepted while idle makes the following true from the next cycle: busy is high, test clock is high, force-receive, force-stop and turn-request are 0, turn-disable is 4'hF, and lane enable is the lowest min(N,4) bits set for lane count N (N=0 gives 4'h0, N of 4 or more gives 4'hF).
- R3: Test clear rises after test clock is high and stays high for exactly WAIT = CLK_MHZ*SETTLE_US cycles. It then stays low for at least WAIT cycles before test enable first rises.
- R4: The band code is taken from the first entry, in ascending order, whose upper bound is greater than or equal to the rate. The entries, as bound:code in hex code, are 89:00 99:10 109:20 129:01 139:11 149:21 169:02 179:12 199:22 219:03 239:13 249:23 269:04 299:14 329:05 359:15 399:25 449:06 499:16 549:07 599:17 649:08 699:18 749:09 799:19 849:29 899:39 949:0a 999:1a 1049:2a 1099:3a 1149:0b 1199:1b 1249:2b 1299:3b 1349:0c 1399:1c 1449:2c 1500:3c.
- R5: A rate above 1500 gives band code 0.
- R6: Each write runs seven steps, each held STEP_CYCLES cycles, in this order: test clock high, address on data, enable high, test clock low, enable low, data byte on data, test clock high. The address is thus presented at a falling test-clock edge with enable high, and the data at a rising edge with enable low. Enable stays high for 2*STEP_CYCLES cycles.
- R7: The writes go out in the order address:data 0x34:0x00, 0x44:(code<<1), 0x54:0x00, 0x84:0x00, 0x94:0x00, 0x75:0x04, 0x00:0x00.
- R8: Done is high for exactly one cycle per sequence, after the final write. Busy is low in that cycle.
- R9: A start request that arrives while busy is ignored. The captured rate and lane settings stay unchanged.
- R10: After done, the lane fields and the high test clock are held, and a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| rate_mbps_i | input | RATE_W | Link data rate in Mbit/s, sampled on start |
| lanes_i | input | 3 | Active lane count, sampled on start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| force_rx_o | output | 4 | Per-lane force-receive control |
| force_stop_o | output | 4 | Per-lane force-stop control |
| turn_req_o | output | 4 | Per-lane turnaround request |
| turn_dis_o | output | 4 | Per-lane turnaround disable |
| lane_en_o | output | 4 | Per-lane enable mask |
| test_clk_o | output | 1 | PHY test port clock |
| test_clr_o | output | 1 | PHY test port clear |
| test_en_o | output | 1 | PHY test port enable (address phase) |
| test_din_o | output | 8 | PHY test port data in |

## Verification
The assertions assume that reset is applied before the first start. They also assume that a start request is a level that is sampled only while idle, so a start held high across the end of a sequence simply starts a new one. The handshake and pulse-width properties rely on STEP_CYCLES and WAIT being at least 1. The stimulus keeps to this. It always raises start for a single cycle, begins with a reset, and sweeps every rate bound and the value just above it. Lane counts from 0 to 7 are applied, along with extra start pulses placed deliberately inside running sequences.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

    localparam int NUM_BANDS  = 39;
    localparam int NUM_WRITES = 7;
    localparam int MAX_RATE   = 1500;

    typedef enum logic [2:0] {
        PH_CLK_HI,
        PH_ADDR,
        PH_EN_HI,
        PH_CLK_LO,
        PH_EN_LO,
        PH_DATA,
        PH_CLK_RISE
    } wr_phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_CLR_HI,
        SQ_CLR_LO,
        SQ_WRITE
    } seq_state_e;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } tp_write_t;

    typedef struct packed {
        logic [10:0] bound;
        logic [5:0]  code;
    } band_t;

    typedef struct packed {
        logic [3:0] force_rx;
        logic [3:0] force_stop;
        logic [3:0] turn_req;
        logic [3:0] turn_dis;
        logic [3:0] lane_en;
    } lane_ctrl_t;

    // Ascending upper rate bounds with their band codes; first match wins.
    function automatic band_t band_at(input int idx);
        case (idx)
            0:  return {11'd89,   6'h00};
            1:  return {11'd99,   6'h10};
            2:  return {11'd109,  6'h20};
            3:  return {11'd129,  6'h01};
            4:  return {11'd139,  6'h11};
            5:  return {11'd149,  6'h21};
            6:  return {11'd169,  6'h02};
            7:  return {11'd179,  6'h12};
            8:  return {11'd199,  6'h22};
            9:  return {11'd219,  6'h03};
            10: return {11'd239,  6'h13};
            11: return {11'd249,  6'h23};
            12: return {11'd269,  6'h04};
            13: return {11'd299,  6'h14};
            14: return {11'd329,  6'h05};
            15: return {11'd359,  6'h15};
            16: return {11'd399,  6'h25};
            17: return {11'd449,  6'h06};
            18: return {11'd499,  6'h16};
            19: return {11'd549,  6'h07};
            20: return {11'd599,  6'h17};
            21: return {11'd649,  6'h08};
            22: return {11'd699,  6'h18};
            23: return {11'd749,  6'h09};
            24: return {11'd799,  6'h19};
            25: return {11'd849,  6'h29};
            26: return {11'd899,  6'h39};
            27: return {11'd949,  6'h0a};
            28: return {11'd999,  6'h1a};
            29: return {11'd1049, 6'h2a};
            30: return {11'd1099, 6'h3a};
            31: return {11'd1149, 6'h0b};
            32: return {11'd1199, 6'h1b};
            33: return {11'd1249, 6'h2b};
            34: return {11'd1299, 6'h3b};
            35: return {11'd1349, 6'h0c};
            36: return {11'd1399, 6'h1c};
            37: return {11'd1449, 6'h2c};
            38: return {11'd1500, 6'h3c};
            default: return '0;
        endcase
    endfunction

    // Ordered configuration writes issued over the test port.
    function automatic tp_write_t write_at(input int idx, input logic [5:0] code);
        case (idx)
            0: return {8'h34, 8'h00};
            1: return {8'h44, {1'b0, code, 1'b0}};
            2: return {8'h54, 8'h00};
            3: return {8'h84, 8'h00};
            4: return {8'h94, 8'h00};
            5: return {8'h75, 8'h04};
            default: return {8'h00, 8'h00};
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input logic [2:0] n);
        if (n >= 3'd4) return 4'hF;
        return 4'((5'd1 << n) - 5'd1);
    endfunction

endpackage

// File: rtl/rate_band_lut.sv
module rate_band_lut
    import dphy_seq_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [5:0]        code_o
);
    // Scan from the top entry down so the lowest matching index is kept.
    always_comb begin
        code_o = '0;
        for (int i = NUM_BANDS - 1; i >= 0; i--) begin
            band_t b;
            b = band_at(i);
            if (int'(rate_i) <= int'(b.bound)) code_o = b.code;
        end
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int WAIT_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic zero_o
);
    localparam int TW = $clog2(WAIT_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load_i)      cnt <= TW'(WAIT_CYC - 1);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    // R3
    tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/tp_writer.sv
module tp_writer
    import dphy_seq_pkg::*;
#(
    parameter int STEP_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      arm_i,
    input  logic      go_i,
    input  tp_write_t wr_i,
    output logic      tclk_o,
    output logic      ten_o,
    output logic [7:0] tdin_o,
    output logic      done_o
);
    localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

    wr_phase_e     phase, ph_next;
    logic [CW-1:0] cnt;
    logic          active;
    tp_write_t     wr_q;

    always_comb ph_next = wr_phase_e'(phase + 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_CLK_HI;
            cnt    <= '0;
            active <= 1'b0;
            wr_q   <= '0;
            tclk_o <= 1'b0;
            ten_o  <= 1'b0;
            tdin_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (arm_i) tclk_o <= 1'b1;
            if (go_i && !active) begin
                active <= 1'b1;
                phase  <= PH_CLK_HI;
                cnt    <= CW'(STEP_CYCLES - 1);
                wr_q   <= wr_i;
                tclk_o <= 1'b1;
            end else if (active) begin
                if (cnt == '0) begin
                    if (phase == PH_CLK_RISE) begin
                        active <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        phase <= ph_next;
                        cnt   <= CW'(STEP_CYCLES - 1);
                        case (ph_next)
                            PH_ADDR:     tdin_o <= wr_q.addr;
                            PH_EN_HI:    ten_o  <= 1'b1;
                            PH_CLK_LO:   tclk_o <= 1'b0;
                            PH_EN_LO:    ten_o  <= 1'b0;
                            PH_DATA:     tdin_o <= wr_q.data;
                            PH_CLK_RISE: tclk_o <= 1'b1;
                            default:     ;
                        endcase
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R6
    addr_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tclk_o) |-> ten_o);
    // R6
    data_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tclk_o) |-> !ten_o);
    // R6
    en_under_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ten_o) |-> tclk_o);
    // R6
    en_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !ten_o);
endmodule

// File: rtl/dphy_rx_startup.sv
module dphy_rx_startup
    import dphy_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int SETTLE_US   = 100,
    parameter int STEP_CYCLES = 4,
    parameter int RATE_W      = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_mbps_i,
    input  logic [2:0]        lanes_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [3:0]        force_rx_o,
    output logic [3:0]        force_stop_o,
    output logic [3:0]        turn_req_o,
    output logic [3:0]        turn_dis_o,
    output logic [3:0]        lane_en_o,
    output logic              test_clk_o,
    output logic              test_clr_o,
    output logic              test_en_o,
    output logic [7:0]        test_din_o
);
    localparam int WAIT_CYC = CLK_MHZ * SETTLE_US;
    localparam int IW       = $clog2(NUM_WRITES);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WRITES - 1);

    seq_state_e        state;
    lane_ctrl_t        ctrl_q;
    logic [RATE_W-1:0] rate_q;
    logic [5:0]        band_code;
    logic [IW-1:0]     idx, go_idx;
    logic              accept, tmr_load, tmr_zero, wr_go, wr_done;
    tp_write_t         wr_cur;

    rate_band_lut #(.RATE_W(RATE_W)) lut_i (
        .rate_i (rate_q),
        .code_o (band_code)
    );

    settle_timer #(.WAIT_CYC(WAIT_CYC)) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .zero_o (tmr_zero)
    );

    always_comb begin
        accept   = (state == SQ_IDLE) && start_i;
        tmr_load = (state == SQ_ARM) || (state == SQ_CLR_HI && tmr_zero);
        wr_go    = (state == SQ_CLR_LO && tmr_zero) ||
                   (state == SQ_WRITE && wr_done && idx != LAST_IDX);
        go_idx   = (state == SQ_CLR_LO) ? '0 : idx + 1'b1;
        wr_cur   = write_at(int'(go_idx), band_code);
    end

    tp_writer #(.STEP_CYCLES(STEP_CYCLES)) wr_i (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (accept),
        .go_i   (wr_go),
        .wr_i   (wr_cur),
        .tclk_o (test_clk_o),
        .ten_o  (test_en_o),
        .tdin_o (test_din_o),
        .done_o (wr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            ctrl_q     <= '0;
            rate_q     <= '0;
            idx        <= '0;
            test_clr_o <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (wr_go) idx <= go_idx;
            case (state)
                SQ_IDLE: if (start_i) begin
                    rate_q            <= rate_mbps_i;
                    ctrl_q.force_rx   <= 4'h0;
                    ctrl_q.force_stop <= 4'h0;
                    ctrl_q.turn_req   <= 4'h0;
                    ctrl_q.turn_dis   <= 4'hF;
                    ctrl_q.lane_en    <= lane_mask(lanes_i);
                    state             <= SQ_ARM;
                end
                SQ_ARM: begin
                    test_clr_o <= 1'b1;
                    state      <= SQ_CLR_HI;
                end
                SQ_CLR_HI: if (tmr_zero) begin
                    test_clr_o <= 1'b0;
                    state      <= SQ_CLR_LO;
                end
                SQ_CLR_LO: if (tmr_zero) state <= SQ_WRITE;
                SQ_WRITE: if (wr_done && idx == LAST_IDX) begin
                    done_o <= 1'b1;
                    state  <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o       = (state != SQ_IDLE);
    assign force_rx_o   = ctrl_q.force_rx;
    assign force_stop_o = ctrl_q.force_stop;
    assign turn_req_o   = ctrl_q.turn_req;
    assign turn_dis_o   = ctrl_q.turn_dis;
    assign lane_en_o    = ctrl_q.lane_en;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    // R3
    clr_busy_chk: assert property (@(posedge clk) disable iff (rst)
        test_clr_o |-> (busy_o && test_clk_o));
    // R9
    ign_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(lane_en_o) && $stable(rate_q)));
    // R2
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({1'b0, lane_en_o} + 5'd1));
    // R2
    turn_dis_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (turn_dis_o == 4'hF && force_rx_o == 4'h0));
    // R5
    band_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && int'(rate_q) > MAX_RATE) |-> (band_code == 6'h00));
endmodule

// File: tb/dphy_rx_startup_tb_top.sv
`timescale 1ns/1ps
module dphy_rx_startup_tb_top;
    localparam int P_MHZ  = 1;
    localparam int P_US   = 10;
    localparam int P_STEP = 2;
    localparam int WAIT   = P_MHZ * P_US;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] rate_in = '0;
    logic [2:0]  lanes_in = '0;
    logic        busy_o, done_o, test_clk_o, test_clr_o, test_en_o;
    logic [3:0]  force_rx_o, force_stop_o, turn_req_o, turn_dis_o, lane_en_o;
    logic [7:0]  test_din_o;

    always #2.5 clk = ~clk;

    dphy_rx_startup #(.CLK_MHZ(P_MHZ), .SETTLE_US(P_US), .STEP_CYCLES(P_STEP), .RATE_W(12)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .rate_mbps_i(rate_in), .lanes_i(lanes_in),
        .busy_o(busy_o), .done_o(done_o), .force_rx_o(force_rx_o), .force_stop_o(force_stop_o),
        .turn_req_o(turn_req_o), .turn_dis_o(turn_dis_o), .lane_en_o(lane_en_o),
        .test_clk_o(test_clk_o), .test_clr_o(test_clr_o), .test_en_o(test_en_o),
        .test_din_o(test_din_o)
    );

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    int bnd [39] = '{89, 99, 109, 129, 139, 149, 169, 179, 199, 219, 239, 249, 269,
                     299, 329, 359, 399, 449, 499, 549, 599, 649, 699, 749, 799, 849,
                     899, 949, 999, 1049, 1099, 1149, 1199, 1249, 1299, 1349, 1399,
                     1449, 1500};
    int cde [39] = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03, 'h13,
                     'h23, 'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07, 'h17, 'h08,
                     'h18, 'h09, 'h19, 'h29, 'h39, 'h0a, 'h1a, 'h2a, 'h3a, 'h0b, 'h1b,
                     'h2b, 'h3b, 'h0c, 'h1c, 'h2c, 'h3c};
    int exp_addr [7] = '{'h34, 'h44, 'h54, 'h84, 'h94, 'h75, 'h00};

    // Monitor state
    int wa [1024];
    int wd [1024];
    int wr_n = 0, clr_cnt = 0, done_cnt = 0, gap_cnt = 0, gap_last = 0;
    int en_len = 0, en_last = 0;
    bit prev_clk = 0, prev_en = 0, prev_clr = 0, have_addr = 0, gap_pend = 0;
    int addr_hold = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int r);
        for (int i = 0; i < 39; i++) if (r <= bnd[i]) return cde[i];
        return 0;
    endfunction

    function automatic int exp_mask(input int n);
        return (n >= 4) ? 15 : ((1 << n) - 1);
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_clk && !test_clk_o && test_en_o) begin
                addr_hold = int'(test_din_o);
                have_addr = 1;
            end
            if (!prev_clk && test_clk_o && !test_en_o && have_addr) begin
                wa[wr_n % 1024] = addr_hold;
                wd[wr_n % 1024] = int'(test_din_o);
                wr_n++;
                have_addr = 0;
            end
            if (test_clr_o) clr_cnt++;
            if (done_o) done_cnt++;
            if (prev_clr && !test_clr_o) begin gap_cnt = 0; gap_pend = 1; end
            else if (gap_pend && !test_clr_o) gap_cnt++;
            if (gap_pend && !prev_en && test_en_o) begin gap_last = gap_cnt; gap_pend = 0; end
            if (test_en_o) en_len++;
            else if (prev_en) begin en_last = en_len; en_len = 0; end
            prev_clk = test_clk_o;
            prev_en  = test_en_o;
            prev_clr = test_clr_o;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic run_seq(input int rate, input int lanes, input bit poke);
        int wbase = wr_n;
        int cbase = clr_cnt;
        int dbase = done_cnt;
        int code  = exp_code(rate);
        int mask  = exp_mask(lanes);
        @(negedge clk);
        start = 1; rate_in = 12'(rate); lanes_in = 3'(lanes);
        @(negedge clk);
        start = 0;
        // R2 fields right after acceptance
        chk(busy_o == 1'b1, "R2 busy", int'(busy_o), 1);
        chk(lane_en_o == 4'(mask), "R2 lane_en", int'(lane_en_o), mask);
        chk(turn_dis_o == 4'hF && force_rx_o == 0 && force_stop_o == 0 && turn_req_o == 0,
            "R2 lane fields", int'({force_rx_o, force_stop_o, turn_req_o, turn_dis_o}), 'h000F);
        chk(test_clk_o == 1'b1, "R2 test_clk", int'(test_clk_o), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1; rate_in = 12'd0; lanes_in = (lanes == 1) ? 3'd4 : 3'd1;
            @(negedge clk);
            start = 0;
            // R9 second start ignored
            chk(lane_en_o == 4'(mask), "R9 lane_en kept", int'(lane_en_o), mask);
        end
        while (!done_o) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(done_cnt - dbase == 1, "R8 done pulses", done_cnt - dbase, 1);
        chk(busy_o == 1'b0, "R8 busy after done", int'(busy_o), 0);
        chk(test_clk_o == 1'b1, "R10 test_clk held", int'(test_clk_o), 1);
        chk(lane_en_o == 4'(mask) && turn_dis_o == 4'hF, "R10 fields held", int'(lane_en_o), mask);
        chk(clr_cnt - cbase == WAIT, "R3 clear width", clr_cnt - cbase, WAIT);
        chk(gap_last >= WAIT, "R3 clear-low gap", gap_last, WAIT);
        chk(en_last == 2 * P_STEP, "R6 enable width", en_last, 2 * P_STEP);
        chk(wr_n - wbase == 7, "R6 write count", wr_n - wbase, 7);
        for (int k = 0; k < 7; k++) begin
            int exp_d;
            int a = wa[(wbase + k) % 1024];
            int d = wd[(wbase + k) % 1024];
            exp_d = (k == 1) ? (code << 1) : ((k == 5) ? 4 : 0);
            chk(a == exp_addr[k], "R7 address", a, exp_addr[k]);
            if (k == 1 && rate > 1500)
                chk(d == exp_d, "R5 out-of-range code", d, exp_d);
            else if (k == 1)
                chk(d == exp_d, "R4 band code", d, exp_d);
            else
                chk(d == exp_d, "R7 data", d, exp_d);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({busy_o, done_o, test_clk_o, test_clr_o, test_en_o} == 5'b0, "R1 controls",
            int'({busy_o, done_o, test_clk_o, test_clr_o, test_en_o}), 0);
        chk({force_rx_o, force_stop_o, turn_req_o, turn_dis_o, lane_en_o, test_din_o} == '0,
            "R1 fields", int'({lane_en_o, turn_dis_o, test_din_o}), 0);
        rst = 0;
        @(negedge clk);
        run_seq(0, 1, 1'b0);
        for (int i = 0; i < 39; i++) begin
            run_seq(bnd[i], i % 8, (i % 4) == 0);
            run_seq(bnd[i] + 1, (i + 3) % 8, 1'b0);
        end
        run_seq(4095, 7, 1'b1);
        run_seq(1, 4, 1'b0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule